// File: doc/BRIEF.md
# Interrupt Router with Two Level Pins and Single-Vector Message Delivery

This block merges a set of internal interrupt sources (by default a reply-event class and a doorbell class) into the signals a host sees. Each source carries a level that stays high while the event is pending. A per-source mask bit decides whether that level counts at all. A two-bit route code decides which of two active-low, level-sensitive pins the source pulls down: the primary pin, the alternate pin, both of them, or neither.

A single control word holds the masks, the route codes and a message-delivery enable. With that enable set, both pins stay released. Delivery then goes through one request line, which rises once for each new rising edge of the combined unmasked pending condition and stays high until the host side acknowledges it. The same mask bits gate both delivery paths. At reset every source is masked, every route points at the primary pin, and message delivery is off.

Top module: `irq_router`

## Requirements
- R1: While reset is held (synchronous, active high), the control word reads 0x17 with the default two sources: both masks set, both routes at code 01, enable clear. Both pins read 1 and the request reads 0.
- R2: The control word has mask bit i at position i (1 = masked) and the route code of source i at bits [N+2i+1:N+2i]. The message enable sits at bit 3N. A write with reg_we loads the word at the clock edge, and reg_rdata shows the stored word at all times.
- R3: A masked source changes neither pin and raises no request, whatever its level.
- R4: Route code 01 selects the primary pin, 10 the alternate pin, 11 both pins and 00 no pin. With message delivery off, a pin is 0 in the cycle after any unmasked, pending source routed to it is sampled.
- R5: A pin returns to 1 in the cycle after no unmasked source routed to it is pending any more.
- R6: While message delivery is enabled, both pins read 1 from the cycle after the enable is stored.
- R7: With message delivery enabled, a rising edge of the OR of all unmasked pending sources makes msi_req 1 in the next cycle.
- R8: The request stays 1 until msi_ack is sampled high, and it drops in the following cycle. A further rising edge while a request is outstanding is merged into that request.
- R9: Clearing the mask of a source that is already pending makes its pin assert in the cycle after the write, or raises a new request when message delivery is on.
- R10: While message delivery is disabled, msi_req is 0 from the cycle after the enable is cleared. Setting the enable while the condition is already true raises no request until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_pend | input | N_SRC | Pending level of each interrupt source |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 3*N_SRC+1 | Control word to store |
| reg_rdata | output | 3*N_SRC+1 | Stored control word |
| irq_pri_n | output | 1 | Primary interrupt pin, active low |
| irq_alt_n | output | 1 | Alternate interrupt pin, active low |
| msi_req | output | 1 | Message delivery request |
| msi_ack | input | 1 | Acknowledge of the outstanding request |

## Verification
The checks assume that msi_ack is only raised while msi_req is high, so that an acknowledge never meets a request in the same edge it is created. The hold property also assumes that the control word is not rewritten in the cycle it watches. The stimulus drives an acknowledge only after it has seen the request high at the sampling point. Control writes are randomized but infrequent. Source levels toggle freely each cycle, so rising edges arrive both while a request is idle and while one is outstanding.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam logic [1:0] ROUTE_NONE = 2'b00;
  localparam logic [1:0] ROUTE_PRI  = 2'b01;
  localparam logic [1:0] ROUTE_ALT  = 2'b10;
  localparam logic [1:0] ROUTE_BOTH = 2'b11;

  // Whether a route code reaches the selected pin (0 = primary, 1 = alternate).
  function automatic logic routes_to(input logic [1:0] code, input logic alt_pin);
    return alt_pin ? code[1] : code[0];
  endfunction

  // Control word width for n sources: masks, route pairs, enable.
  function automatic int unsigned ctrl_width(input int unsigned n);
    return 3 * n + 1;
  endfunction

endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_router_pkg::*;
#(
  parameter int unsigned N  = 2,
  parameter int unsigned CW = ctrl_width(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] ctrl
);

  function automatic logic [CW-1:0] reset_word();
    logic [CW-1:0] w;
    w = '0;
    for (int i = 0; i < int'(N); i++) begin
      w[i]         = 1'b1;
      w[N+2*i +: 2] = ROUTE_PRI;
    end
    return w;
  endfunction

  localparam logic [CW-1:0] RST_WORD = reset_word();

  always_ff @(posedge clk) begin
    if (rst)     ctrl <= RST_WORD;
    else if (we) ctrl <= wdata;
  end

endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate
  import irq_router_pkg::*;
#(
  parameter int unsigned N  = 2,
  parameter int unsigned CW = ctrl_width(N)
) (
  input  logic [N-1:0]  src,
  input  logic [CW-1:0] ctrl,
  output logic [N-1:0]  act,
  output logic [N-1:0]  hit_pri,
  output logic [N-1:0]  hit_alt,
  output logic          msi_en
);

  assign msi_en = ctrl[3*N];

  for (genvar i = 0; i < int'(N); i++) begin : g_src
    logic [1:0] code;
    assign code       = ctrl[N+2*i +: 2];
    assign act[i]     = src[i] & ~ctrl[i];
    assign hit_pri[i] = act[i] & routes_to(code, 1'b0);
    assign hit_alt[i] = act[i] & routes_to(code, 1'b1);
  end

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         msi_en,
  input  logic [N-1:0] hit_pri,
  input  logic [N-1:0] hit_alt,
  output logic         pri_n,
  output logic         alt_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_n <= 1'b1;
      alt_n <= 1'b1;
    end else begin
      pri_n <= msi_en | ~(|hit_pri);
      alt_n <= msi_en | ~(|hit_alt);
    end
  end

endmodule

// File: rtl/irq_msi_gen.sv
module irq_msi_gen #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         msi_en,
  input  logic [N-1:0] act,
  input  logic         ack,
  output logic         rise,
  output logic         req
);

  logic any_act, any_q;

  assign any_act = |act;
  assign rise    = msi_en & any_act & ~any_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      any_q <= 1'b0;
      req   <= 1'b0;
    end else begin
      any_q <= any_act;
      req   <= msi_en & ((req & ~ack) | rise);
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC = 2,
  localparam int unsigned CW   = 3 * N_SRC + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_pend,
  input  logic             reg_we,
  input  logic [CW-1:0]    reg_wdata,
  output logic [CW-1:0]    reg_rdata,
  output logic             irq_pri_n,
  output logic             irq_alt_n,
  output logic             msi_req,
  input  logic             msi_ack
);

  logic [CW-1:0]    ctrl;
  logic [N_SRC-1:0] act, hit_pri, hit_alt;
  logic             msi_en, msi_rise;

  irq_ctrl_reg #(.N(N_SRC), .CW(CW)) u_reg (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .ctrl(ctrl)
  );

  irq_route_gate #(.N(N_SRC), .CW(CW)) u_gate (
    .src(src_pend), .ctrl(ctrl), .act(act),
    .hit_pri(hit_pri), .hit_alt(hit_alt), .msi_en(msi_en)
  );

  irq_pin_drv #(.N(N_SRC)) u_pins (
    .clk(clk), .rst(rst), .msi_en(msi_en),
    .hit_pri(hit_pri), .hit_alt(hit_alt),
    .pri_n(irq_pri_n), .alt_n(irq_alt_n)
  );

  irq_msi_gen #(.N(N_SRC)) u_msi (
    .clk(clk), .rst(rst), .msi_en(msi_en), .act(act),
    .ack(msi_ack), .rise(msi_rise), .req(msi_req)
  );

  assign reg_rdata = ctrl;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned N = 2,
  localparam int unsigned CW = 3 * N + 1
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] ctrl,
  input logic [N-1:0]  act,
  input logic          msi_en,
  input logic          msi_rise,
  input logic          reg_we,
  input logic          irq_pri_n,
  input logic          irq_alt_n,
  input logic          msi_req,
  input logic          msi_ack
);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R1: reset leaves every source masked, primary routes, no message delivery
  a_r1_reset_state: assert property (@(posedge clk)
    past_ok && $past(rst) |-> (ctrl[N-1:0] == '1) && !ctrl[3*N]
                              && irq_pri_n && irq_alt_n && !msi_req);

  // R3: no unmasked source pending means no pin and no new request
  a_r3_masked_silent: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(act == '0) |-> irq_pri_n && irq_alt_n && !$rose(msi_req));

  // R6: message delivery keeps both pins released
  a_r6_pins_quiet: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(msi_en) |-> irq_pri_n && irq_alt_n);

  // R7: a detected edge becomes a request
  a_r7_edge_req: assert property (@(posedge clk) disable iff (rst)
    msi_rise |=> msi_req);

  // R8: request held until acknowledged
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    msi_req && !msi_ack && msi_en && !reg_we |=> msi_req);

  // R10: no request while delivery is off
  a_r10_off_clear: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(msi_en) |-> !msi_req);

endmodule

bind irq_router irq_router_chk #(.N(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .act(act), .msi_en(msi_en),
  .msi_rise(msi_rise), .reg_we(reg_we), .irq_pri_n(irq_pri_n),
  .irq_alt_n(irq_alt_n), .msi_req(msi_req), .msi_ack(msi_ack)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;

  localparam int N  = 2;
  localparam int CW = 3 * N + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_pend = '0;
  logic          reg_we = 1'b0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic          irq_pri_n, irq_alt_n, msi_req;
  logic          msi_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the visible state
  logic [CW-1:0] m_ctrl;
  logic          m_pri_n, m_alt_n, m_any, m_req;

  always #5 clk = ~clk;

  irq_router #(.N_SRC(N)) u0 (
    .clk(clk), .rst(rst), .src_pend(src_pend), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pri_n(irq_pri_n),
    .irq_alt_n(irq_alt_n), .msi_req(msi_req), .msi_ack(msi_ack)
  );

  // pending and unmasked sources under a given control word
  function automatic logic [N-1:0] live(input logic [CW-1:0] c, input logic [N-1:0] s);
    return s & ~c[N-1:0];
  endfunction

  // is the given pin (0 primary, 1 alternate) pulled by any live source
  function automatic logic pulled(input logic [CW-1:0] c, input logic [N-1:0] s, input int pin);
    logic r = 1'b0;
    logic [N-1:0] l = live(c, s);
    for (int i = 0; i < N; i++)
      if (l[i] && c[N + 2*i + pin]) r = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (irq_pri_n !== m_pri_n || irq_alt_n !== m_alt_n ||
        msi_req !== m_req || reg_rdata !== m_ctrl) begin
      errors++;
      $display("FAIL %s: pri_n=%b alt_n=%b req=%b rd=%h expected pri_n=%b alt_n=%b req=%b rd=%h",
               tag, irq_pri_n, irq_alt_n, msi_req, reg_rdata,
               m_pri_n, m_alt_n, m_req, m_ctrl);
    end
  endtask

  // called just after a falling edge; applies inputs for one clock and checks
  task automatic step(input string tag, input logic [N-1:0] s, input logic we,
                      input logic [CW-1:0] wd, input logic ak);
    logic en, any_n;
    src_pend = s; reg_we = we; reg_wdata = wd; msi_ack = ak;
    en    = m_ctrl[3*N];
    any_n = |live(m_ctrl, s);
    m_pri_n = en | ~pulled(m_ctrl, s, 0);
    m_alt_n = en | ~pulled(m_ctrl, s, 1);
    m_req   = en & ((m_req & ~ak) | (any_n & ~m_any));
    m_any   = any_n;
    if (we) m_ctrl = wd;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [CW-1:0] word(input logic en, input logic [1:0] r1,
                                         input logic [1:0] r0, input logic [1:0] mk);
    return {en, r1, r0, mk};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ctrl = 7'h17; m_pri_n = 1'b1; m_alt_n = 1'b1; m_any = 1'b0; m_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    src_pend = 2'b11;
    @(posedge clk); @(negedge clk);
    check("R1 reset state");
    rst = 1'b0;
    step("R1 masked after reset", 2'b11, 1'b0, '0, 1'b0);

    // R2: write, read back
    step("R2 write", 2'b00, 1'b1, word(1'b0, 2'b10, 2'b01, 2'b10), 1'b0);
    step("R2 readback", 2'b00, 1'b0, '0, 1'b0);

    // R9: pending while masked, then unmask
    step("R9 masked pending", 2'b01, 1'b1, word(1'b0, 2'b10, 2'b01, 2'b11), 1'b0);
    step("R9 still masked", 2'b01, 1'b1, word(1'b0, 2'b10, 2'b01, 2'b00), 1'b0);
    step("R9 pin after unmask", 2'b01, 1'b0, '0, 1'b0);

    // R4: routing codes
    step("R4 doorbell to alt", 2'b10, 1'b0, '0, 1'b0);
    step("R4 both pins", 2'b11, 1'b1, word(1'b0, 2'b11, 2'b00, 2'b00), 1'b0);
    step("R4 both pins active", 2'b11, 1'b0, '0, 1'b0);
    step("R4 route none", 2'b01, 1'b0, '0, 1'b0);
    // R5: level release
    step("R5 released", 2'b00, 1'b0, '0, 1'b0);
    // R3: mask doorbell while pending
    step("R3 mask doorbell", 2'b10, 1'b1, word(1'b0, 2'b11, 2'b11, 2'b10), 1'b0);
    step("R3 doorbell ignored", 2'b10, 1'b0, '0, 1'b0);

    // R6/R7: message mode
    step("R6 enable msg", 2'b00, 1'b1, word(1'b1, 2'b11, 2'b11, 2'b00), 1'b0);
    step("R7 edge", 2'b01, 1'b0, '0, 1'b0);
    step("R6 pins quiet", 2'b01, 1'b0, '0, 1'b0);
    step("R8 merged edge", 2'b10, 1'b0, '0, 1'b0);
    step("R8 held", 2'b00, 1'b0, '0, 1'b0);
    step("R8 ack", 2'b00, 1'b0, '0, 1'b1);
    step("R8 idle", 2'b00, 1'b0, '0, 1'b0);
    // R9 in message mode
    step("R9 msg masked", 2'b01, 1'b1, word(1'b1, 2'b11, 2'b11, 2'b01), 1'b0);
    step("R9 msg masked hold", 2'b01, 1'b1, word(1'b1, 2'b11, 2'b11, 2'b00), 1'b0);
    step("R9 msg unmask req", 2'b01, 1'b0, '0, 1'b0);
    // R10: disable clears the request
    step("R10 disable", 2'b01, 1'b1, word(1'b0, 2'b11, 2'b11, 2'b00), 1'b0);
    step("R10 cleared", 2'b01, 1'b0, '0, 1'b0);
    step("R10 enable no edge", 2'b01, 1'b1, word(1'b1, 2'b11, 2'b11, 2'b00), 1'b0);
    step("R10 no req", 2'b01, 1'b0, '0, 1'b0);

    // random phase
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] s;
      logic we, ak;
      logic [CW-1:0] wd;
      s  = N'($urandom);
      we = ($urandom % 12) == 0;
      wd = CW'($urandom);
      ak = msi_req && (($urandom % 3) == 0);
      step("R4/R7 random", s, we, wd, ak);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule